// File: doc/BRIEF.md
# Hardware-Synchronized Frame Capture Controller

This block sits between a parallel camera bus and a downstream byte stream, for example the write side of a DMA buffer. On every pixel clock it samples an 8-bit data word together with a line sync and a frame sync. Either sync, while in its configured active level, marks blanking, and any byte present then is thrown away. The remaining bytes are forwarded with a valid strobe. The first forwarded byte of each frame carries a frame-start marker.

Software enables capture with a start pulse. The block does not begin forwarding at once. It waits for the frame sync to leave its active level, which is the start of the next frame. In continuous mode frames then follow one another with no re-arming. In single mode the enable drops by itself once one frame has ended. A stop pulse lets the frame in progress finish and suppresses every frame after it. At each end of a captured frame, a sticky flag is raised so that software can swap buffers. A clear pulse resets the flag.

Top module: `fcap_top`

## Requirements
- R1: A byte sampled while the line sync is at its active level never appears on the output.
- R2: A byte sampled while the frame sync is at its active level never appears on the output.
- R3: After capture is enabled, no byte is output until the frame sync goes from active to inactive. A frame already in progress when the enable arrives is skipped entirely.
- R4: In continuous mode (cfg_single = 0), every frame that follows the first captured one is delivered in full with no further start pulse.
- R5: frame_flag rises two clock cycles after the frame sync turns active at the end of a captured frame. Frames that were not captured do not set it.
- R6: frame_flag stays high until a flag_clr pulse clears it on the next clock edge. If a frame end and a clear fall in the same cycle, the flag is set.
- R7: cfg_hs_pol and cfg_vs_pol each select the active level of their sync: 1 means active high and 0 means active low.
- R8: With cfg_single = 1, cap_on drops at the end of the first captured frame, and no later frame is delivered.
- R9: A cap_stop pulse in the middle of a frame leaves that frame complete on the output. No later frame is output, and cap_on reads 0.
- R10: A byte accepted at the input appears on out_data with out_valid high exactly two clock cycles later. out_sof is high only on the first output byte of each frame.
- R11: While reset is held and just after it, out_valid, out_sof, frame_flag and cap_on are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hs_pol | input | 1 | Active level of hsync (1 = high) |
| cfg_vs_pol | input | 1 | Active level of vsync (1 = high) |
| cfg_single | input | 1 | 1 = capture one frame then disable |
| cap_start | input | 1 | Pulse: enable capture |
| cap_stop | input | 1 | Pulse: disable capture at next frame end (wins over cap_start) |
| flag_clr | input | 1 | Pulse: clear frame_flag |
| pix_data | input | DW | Pixel byte |
| hsync | input | 1 | Line sync (blanking qualifier) |
| vsync | input | 1 | Frame sync (blanking qualifier) |
| out_valid | output | 1 | out_data holds an accepted byte |
| out_data | output | DW | Forwarded pixel byte |
| out_sof | output | 1 | First byte of a frame |
| frame_flag | output | 1 | Sticky end-of-captured-frame flag |
| cap_on | output | 1 | Capture enable state |

## Verification
The bench builds the block with its default DW = 8. Random line lengths, blanking widths and line counts then cover single-byte gaps and back-to-back lines. Both sync polarities are exercised, including the mixed setting in which hsync is active high and vsync active low. This makes an inverted or swapped polarity decode visible as extra or missing bytes. Enable, stop and single-mode pulses are placed mid-frame and inside vertical blanking, so the arming wait and the finish-the-frame rule both show in the byte stream.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2
    } fcap_state_e;

    // Normalized sync view after the input register stage
    typedef struct packed {
        logic hs_act;
        logic vs_act;
        logic vs_rise;
        logic vs_fall;
    } fcap_sync_t;

    // Control decisions for one sample
    typedef struct packed {
        logic accept;
        logic sof;
        logic frame_end;
    } fcap_ctl_t;

    function automatic logic lvl_active(input logic lvl, input logic pol);
        return lvl == pol;
    endfunction

endpackage

// File: rtl/fcap_sync_qual.sv
module fcap_sync_qual
    import fcap_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_hs_pol,
    input  logic          cfg_vs_pol,
    input  logic [DW-1:0] pix_data,
    input  logic          hsync,
    input  logic          vsync,
    output logic [DW-1:0] smp_data,
    output fcap_sync_t    smp_sync
);

    logic [DW-1:0] data_q;
    logic          hs_q;
    logic          vs_q;
    logic          vs_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            hs_q      <= 1'b0;
            vs_q      <= 1'b0;
            vs_prev_q <= 1'b0;
        end else begin
            data_q    <= pix_data;
            hs_q      <= lvl_active(hsync, cfg_hs_pol);
            vs_q      <= lvl_active(vsync, cfg_vs_pol);
            vs_prev_q <= vs_q;
        end
    end

    always_comb begin
        smp_data         = data_q;
        smp_sync.hs_act  = hs_q;
        smp_sync.vs_act  = vs_q;
        smp_sync.vs_rise = vs_q & ~vs_prev_q;
        smp_sync.vs_fall = ~vs_q & vs_prev_q;
    end

endmodule

// File: rtl/fcap_ctrl.sv
module fcap_ctrl
    import fcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_single,
    input  logic        cap_start,
    input  logic        cap_stop,
    input  logic        flag_clr,
    input  fcap_sync_t  smp_sync,
    output fcap_ctl_t   ctl,
    output logic        cap_on,
    output logic        frame_flag,
    output fcap_state_e state
);

    fcap_state_e state_q, state_d;
    logic        en_q, en_d;
    logic        first_q, first_d;
    logic        flag_q, flag_d;
    logic        frame_start;
    logic        in_frame;

    always_comb begin
        frame_start   = (state_q == ST_ARMED) && en_q && smp_sync.vs_fall;
        in_frame      = (state_q == ST_CAPTURE) || frame_start;
        ctl.accept    = in_frame && !smp_sync.hs_act && !smp_sync.vs_act;
        ctl.sof       = ctl.accept && (frame_start || first_q);
        ctl.frame_end = (state_q == ST_CAPTURE) && smp_sync.vs_rise;
    end

    // Enable register: stop wins, single mode self-clears at frame end
    always_comb begin
        en_d = en_q;
        if (cap_stop)
            en_d = 1'b0;
        else if (cap_start)
            en_d = 1'b1;
        else if (ctl.frame_end && cfg_single)
            en_d = 1'b0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_q)
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!en_q)
                    state_d = ST_IDLE;
                else if (smp_sync.vs_fall)
                    state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (smp_sync.vs_rise)
                    state_d = (en_q && !cfg_single) ? ST_ARMED : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        first_d = first_q;
        if (frame_start)
            first_d = !ctl.accept;
        else if (ctl.accept || ctl.frame_end)
            first_d = 1'b0;
    end

    // Sticky flag, set has priority over clear
    always_comb begin
        flag_d = flag_q;
        if (ctl.frame_end)
            flag_d = 1'b1;
        else if (flag_clr)
            flag_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
            first_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
            first_q <= first_d;
            flag_q  <= flag_d;
        end
    end

    assign cap_on     = en_q;
    assign frame_flag = flag_q;
    assign state      = state_q;

endmodule

// File: rtl/fcap_out_stage.sv
module fcap_out_stage
    import fcap_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  fcap_ctl_t     ctl,
    input  logic [DW-1:0] smp_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sof
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctl.accept;
            out_sof   <= ctl.sof;
            if (ctl.accept)
                out_data <= smp_data;
        end
    end

endmodule

// File: rtl/fcap_top.sv
module fcap_top
    import fcap_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_hs_pol,
    input  logic          cfg_vs_pol,
    input  logic          cfg_single,
    input  logic          cap_start,
    input  logic          cap_stop,
    input  logic          flag_clr,
    input  logic [DW-1:0] pix_data,
    input  logic          hsync,
    input  logic          vsync,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sof,
    output logic          frame_flag,
    output logic          cap_on
);

    logic [DW-1:0] smp_data;
    fcap_sync_t    smp_sync;
    fcap_ctl_t     ctl;
    fcap_state_e   fsm_state;

    fcap_sync_qual #(.DW(DW)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .cfg_hs_pol(cfg_hs_pol),
        .cfg_vs_pol(cfg_vs_pol),
        .pix_data  (pix_data),
        .hsync     (hsync),
        .vsync     (vsync),
        .smp_data  (smp_data),
        .smp_sync  (smp_sync)
    );

    fcap_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_single(cfg_single),
        .cap_start (cap_start),
        .cap_stop  (cap_stop),
        .flag_clr  (flag_clr),
        .smp_sync  (smp_sync),
        .ctl       (ctl),
        .cap_on    (cap_on),
        .frame_flag(frame_flag),
        .state     (fsm_state)
    );

    fcap_out_stage #(.DW(DW)) u_out (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .smp_data (smp_data),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_sof  (out_sof)
    );

endmodule

// File: rtl/fcap_checker.sv
module fcap_checker
    import fcap_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_hs_pol,
    input logic          cfg_vs_pol,
    input logic          flag_clr,
    input logic [DW-1:0] pix_data,
    input logic          hsync,
    input logic          vsync,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          out_sof,
    input logic          frame_flag,
    input fcap_state_e   fsm_state
);

    assert_hblank_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(hsync, 2) != $past(cfg_hs_pol, 2)));

    assert_vblank_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(vsync, 2) != $past(cfg_vs_pol, 2)));

    assert_not_idle_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(fsm_state) != ST_IDLE));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_flag && !flag_clr) |=> frame_flag);

    assert_data_latency_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data == $past(pix_data, 2)));

    assert_sof_valid_R10: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

endmodule

bind fcap_top fcap_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_hs_pol(cfg_hs_pol),
    .cfg_vs_pol(cfg_vs_pol),
    .flag_clr  (flag_clr),
    .pix_data  (pix_data),
    .hsync     (hsync),
    .vsync     (vsync),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .frame_flag(frame_flag),
    .fsm_state (fsm_state)
);

// File: tb/fcap_top_tb.sv
`timescale 1ns/1ps
module fcap_top_tb;

    localparam int DW = 8;
    localparam int VB = 8;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_hs_pol = 1'b1;
    logic          cfg_vs_pol = 1'b1;
    logic          cfg_single = 1'b0;
    logic          cap_start = 1'b0;
    logic          cap_stop = 1'b0;
    logic          flag_clr = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic          hsync = 1'b0;
    logic          vsync = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_sof;
    logic          frame_flag;
    logic          cap_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit prev_cap = 1'b0;
    bit p_start = 1'b0;
    bit p_stop = 1'b0;
    bit p_clr = 1'b0;
    logic [DW:0] exp_q[$];

    always #2.5 clk = ~clk;

    fcap_top #(.DW(DW)) u_dut (
        .clk(clk), .rst(rst), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
        .cfg_single(cfg_single), .cap_start(cap_start), .cap_stop(cap_stop),
        .flag_clr(flag_clr), .pix_data(pix_data), .hsync(hsync), .vsync(vsync),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .frame_flag(frame_flag), .cap_on(cap_on)
    );

    function automatic logic phys(input bit act, input logic pol);
        return act ? pol : ~pol;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One pixel-clock cycle of stimulus, driven on the falling edge
    task automatic cyc(input bit hs_act, input bit vs_act, input logic [DW-1:0] d);
        @(negedge clk);
        hsync     = phys(hs_act, cfg_hs_pol);
        vsync     = phys(vs_act, cfg_vs_pol);
        pix_data  = d;
        cap_start = p_start;
        cap_stop  = p_stop;
        flag_clr  = p_clr;
        p_start = 1'b0;
        p_stop  = 1'b0;
        p_clr   = 1'b0;
    endtask

    task automatic hold_vblank(input int n);
        for (int i = 0; i < n; i++)
            cyc(($urandom % 2) == 1, 1'b1, DW'($urandom));
    endtask

    // Vertical blank then active lines; the frame ends when the next blank begins
    task automatic drive_frame(input bit expect_cap, input int start_line,
                               input int stop_line, input bit do_clr);
        int lines;
        int width;
        int hblank;
        bit first;
        lines = 2 + ($urandom % 3);
        first = 1'b1;
        for (int i = 0; i < VB; i++) begin
            if (i == 4) begin
                chk("R5 flag after frame end", frame_flag, prev_cap);
                if (do_clr) p_clr = 1'b1;
            end
            if (i == 6 && do_clr)
                chk("R6 flag cleared by pulse", frame_flag, 1'b0);
            cyc(($urandom % 2) == 1, 1'b1, DW'($urandom));
        end
        if (!do_clr)
            chk("R6 flag stays set without clear", frame_flag, prev_cap);
        for (int l = 0; l < lines; l++) begin
            width  = 1 + ($urandom % 12);
            hblank = 1 + ($urandom % 5);
            for (int b = 0; b < width; b++) begin
                logic [DW-1:0] d;
                d = DW'($urandom);
                if (b == 0 && l == start_line) p_start = 1'b1;
                if (b == 0 && l == stop_line)  p_stop  = 1'b1;
                cyc(1'b0, 1'b0, d);
                if (expect_cap) begin
                    exp_q.push_back({first, d});
                    first = 1'b0;
                end
            end
            for (int h = 0; h < hblank; h++)
                cyc(1'b1, 1'b0, DW'($urandom));
        end
        prev_cap = expect_cap;
    endtask

    // Output monitor: every valid byte must match the expected stream
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1/R2/R3: actual unexpected byte %0h expected none", out_data);
            end else begin
                logic [DW:0] e;
                e = exp_q.pop_front();
                if ({out_sof, out_data} !== e) begin
                    errors++;
                    $display("FAIL R10: actual sof=%0b data=%0h expected sof=%0b data=%0h",
                             out_sof, out_data, e[DW], e[DW-1:0]);
                end
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R11 out_valid in reset", out_valid, 1'b0);
        chk("R11 frame_flag in reset", frame_flag, 1'b0);
        chk("R11 cap_on in reset", cap_on, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 out_sof after reset", out_sof, 1'b0);
        chk("R11 cap_on after reset", cap_on, 1'b0);

        // R3: enable arrives mid-frame, that frame is skipped
        hold_vblank(10);
        drive_frame(1'b0, 1, -1, 1'b1);
        chk("R3 cap_on after start", cap_on, 1'b1);
        // R4: back-to-back continuous frames
        drive_frame(1'b1, -1, -1, 1'b1);
        drive_frame(1'b1, -1, -1, 1'b1);
        // R9: stop in the middle of a frame; R6 sticky (no clear)
        drive_frame(1'b1, -1, 1, 1'b0);
        chk("R9 cap_on after stop", cap_on, 1'b0);
        drive_frame(1'b0, -1, -1, 1'b1);
        drive_frame(1'b0, -1, -1, 1'b1);
        chk("R9 queue drained", exp_q.size(), 0);

        // R8: single frame
        cfg_single = 1'b1;
        hold_vblank(3);
        p_start = 1'b1;
        hold_vblank(3);
        drive_frame(1'b1, -1, -1, 1'b1);
        drive_frame(1'b0, -1, -1, 1'b1);
        chk("R8 cap_on cleared after one frame", cap_on, 1'b0);
        drive_frame(1'b0, -1, -1, 1'b1);

        // R7: active-low syncs
        cfg_single = 1'b0;
        cfg_hs_pol = 1'b0;
        cfg_vs_pol = 1'b0;
        hold_vblank(6);
        p_start = 1'b1;
        hold_vblank(3);
        drive_frame(1'b1, -1, -1, 1'b1);
        drive_frame(1'b1, -1, -1, 1'b1);
        hold_vblank(2);
        p_stop = 1'b1;
        hold_vblank(2);
        drive_frame(1'b0, -1, -1, 1'b1);

        // R7: mixed polarity
        cfg_hs_pol = 1'b1;
        cfg_vs_pol = 1'b0;
        hold_vblank(6);
        p_start = 1'b1;
        hold_vblank(3);
        drive_frame(1'b1, -1, -1, 1'b1);
        drive_frame(1'b1, -1, -1, 1'b1);
        hold_vblank(6);
        chk("R5 flag at final frame end", frame_flag, 1'b1);
        chk("R4 all expected bytes delivered", exp_q.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule